// File: doc/BRIEF.md
# UART Receiver With Sleep and Wakeup

This block turns an asynchronous serial line into characters. It oversamples the line on a sample-enable input (one pulse per sixteenth of a bit time by default), looks for a valid start bit, recovers each bit by a three-sample majority vote, and builds a character of 8 or 9 bits. When parity is enabled, the top bit of the character is the parity bit, and the block checks it against the selected even or odd sense.

A sleep state lets a node ignore traffic meant for other nodes. A one-cycle request puts the receiver to sleep. While it sleeps it still tracks frames but reports none of them. A wake-rule input picks how sleep ends. One rule ends it when the top bit of a received character is 1 (an address mark), and that character is delivered. The other rule ends it when the line has been idle for one full frame length. A second input sets where idle counting begins: at the start bit, so that trailing 1 data bits and the stop bit count, or only after the stop bit.

Top module: `uart_wake_rx`

## Requirements
- R1: In 8-bit mode (`nine_bit_mode`=0, no parity) a frame of one start bit, 8 bits LSB first and one stop bit gives `rx_data[7:0]` equal to the bits sent with `rx_data[8]`=0, and `rx_ready` high for exactly one cycle.
- R2: In 9-bit mode (`nine_bit_mode`=1) the receiver takes 9 bits LSB first and delivers them all on `rx_data[8:0]`.
- R3: With `parity_en`=1 the top character bit (bit 7 in 8-bit mode, bit 8 in 9-bit mode) is parity. `parity_err` is updated with each `rx_ready`. It is 1 when the number of 1s across all character bits is odd for `parity_odd`=0 or even for `parity_odd`=1. With `parity_en`=0 it is 0.
- R4: A falling edge whose majority at samples 7, 8 and 9 of the start bit is high is dropped as noise, and no character is reported.
- R5: Each bit is the majority of samples 7, 8 and 9 of its 16 sample pulses, so a single wrong sample at sample 8 does not alter the character.
- R6: After a one-cycle `sleep_req`, `asleep` is 1 and `rx_ready` stays 0 for every frame that does not wake the receiver.
- R7: With `wake_on_mark`=0, a sleeping receiver wakes on an idle line. Characters are delivered again after that.
- R8: With `wake_on_mark`=1, a character whose top bit is 1 clears `asleep` and is delivered. Idle lines and characters with top bit 0 leave it asleep.
- R9: The top bit used for the address mark is bit 7 in 8-bit mode and bit 8 in 9-bit mode.
- R10: With `idle_after_stop`=0, consecutive 1 bits are counted from after the start bit (data and stop bits included). `idle_flag` pulses for one cycle when the count reaches the frame length of 10 bits in 8-bit mode.
- R11: With `idle_after_stop`=1, counting starts only after the stop bit, so 10 idle bit times must follow the stop bit.
- R12: In 9-bit mode the idle threshold is 11 bit times.
- R13: During and after reset, `rx_ready`, `parity_err`, `idle_flag` and `asleep` are 0. `idle_flag` fires at most once after each accepted start bit or sleep entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Oversampling enable, OVS pulses per bit time |
| rx_line | input | 1 | Serial receive line, idle high |
| nine_bit_mode | input | 1 | 1 = 9-bit characters, 0 = 8-bit |
| parity_en | input | 1 | Top character bit is parity |
| parity_odd | input | 1 | 1 = odd parity, 0 = even |
| wake_on_mark | input | 1 | 1 = address-mark wakeup, 0 = idle-line wakeup |
| idle_after_stop | input | 1 | 1 = idle counting starts after the stop bit, 0 = after the start bit |
| sleep_req | input | 1 | One-cycle request to enter sleep |
| rx_data | output | CHAR_W | Last delivered character |
| rx_ready | output | 1 | One-cycle pulse when a character is delivered |
| parity_err | output | 1 | Parity result for the last delivered character |
| idle_flag | output | 1 | One-cycle pulse on idle detection |
| asleep | output | 1 | Receiver is in the sleep state |

## Verification
The bench sends all-ones characters under both idle-count modes and checks for the idle pulse inside narrow windows. A design that counts from the wrong point fires about nine bit times early or late. A design with a fixed threshold fails the 9-bit window. For the address-mark tests it picks characters in which only bit 7 or only bit 8 is set, so a design that reads the wrong top bit wakes on the wrong one. It also holds the line idle in mark mode to catch a design that wakes on any rule. A runt start pulse and single-sample glitches inside data bits show whether a design accepts noise as a start bit or trusts a single sample.

// File: rtl/uart_wr_pkg.sv
package uart_wr_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_t;
endpackage

// File: rtl/uart_wr_vote.sv
module uart_wr_vote #(
   parameter int OVS = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic                    rx,
   input  logic [$clog2(OVS)-1:0]  ph,
   output logic                    vote
);
   localparam int PW = $clog2(OVS);
   localparam logic [PW-1:0] PH_A = PW'(OVS / 2 - 2);
   localparam logic [PW-1:0] PH_B = PW'(OVS / 2 - 1);

   logic s_a, s_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_a <= 1'b1;
         s_b <= 1'b1;
      end else if (tick) begin
         if (ph == PH_A) s_a <= rx;
         if (ph == PH_B) s_b <= rx;
      end
   end

   // third sample is the live line at the middle phase
   assign vote = (s_a & s_b) | (s_a & rx) | (s_b & rx);
endmodule

// File: rtl/uart_wr_idle.sv
module uart_wr_idle #(
   parameter int OVS    = 16,
   parameter int MAXLEN = 11,
   parameter int CW     = $clog2(MAXLEN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          in_idle,
   input  logic          rx,
   input  logic          bit_strobe,
   input  logic          bit_val,
   input  logic          count_frame,
   input  logic          restart,
   input  logic [CW-1:0] frame_len,
   output logic          idle_hit
);
   localparam int PW = $clog2(OVS);
   localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);

   logic [PW-1:0] iph;
   logic [CW-1:0] cnt, cnt_inc;
   logic          armed, bit_tick;

   // bit-time timer while the receiver waits on a high line
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        iph <= '0;
      else if (!in_idle) iph <= '0;
      else if (tick)     iph <= rx ? iph + 1'b1 : '0;
   end

   assign bit_tick = in_idle && tick && rx && (iph == PH_LAST);
   assign cnt_inc  = (cnt >= frame_len) ? cnt : cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
      end else begin
         if (restart)         cnt <= '0;
         else if (bit_strobe) cnt <= (count_frame && bit_val) ? cnt_inc : '0;
         else if (bit_tick)   cnt <= cnt_inc;

         if (restart)       armed <= 1'b1;
         else if (idle_hit) armed <= 1'b0;
      end
   end

   assign idle_hit = armed && (cnt >= frame_len);

   // R13
   idle_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_hit |=> !idle_hit);
   // R12
   idle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(MAXLEN));
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
   parameter int OVS          = 16,
   parameter int CHAR_W       = 9,
   parameter bit USE_MAJORITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_tick,
   input  logic              rx_line,
   input  logic              nine_bit_mode,
   input  logic              parity_en,
   input  logic              parity_odd,
   input  logic              wake_on_mark,
   input  logic              idle_after_stop,
   input  logic              sleep_req,
   output logic [CHAR_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              parity_err,
   output logic              idle_flag,
   output logic              asleep
);
   import uart_wr_pkg::*;

   localparam int PW     = $clog2(OVS);
   localparam int BW     = $clog2(CHAR_W + 1);
   localparam int MAXLEN = CHAR_W + 2;
   localparam int CW     = $clog2(MAXLEN + 1);
   localparam logic [PW-1:0] PH_MID  = PW'(OVS / 2);
   localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);

   if (OVS < 8 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("OVS must be a power of two, 8 or more");
   end
   if (CHAR_W < 2) begin : g_bad_char
      $error("CHAR_W must be at least 2");
   end

   rx_state_t         state;
   logic [PW-1:0]     ph;
   logic [BW-1:0]     bitcnt, nbits;
   logic [CHAR_W-1:0] shreg;
   logic [CW-1:0]     frame_len;
   logic              vote, at_mid, start_ok, bit_strobe, frame_done;
   logic              msb, par_bad, wake_mark, deliver, idle_hit;

   if (USE_MAJORITY) begin : g_vote
      uart_wr_vote #(.OVS(OVS)) u_vote (
         .clk  (clk),
         .rst_n(rst_n),
         .tick (sample_tick),
         .rx   (rx_line),
         .ph   (ph),
         .vote (vote)
      );
   end else begin : g_single
      assign vote = rx_line;
   end

   assign nbits      = nine_bit_mode ? BW'(CHAR_W) : BW'(CHAR_W - 1);
   assign frame_len  = nine_bit_mode ? CW'(CHAR_W + 2) : CW'(CHAR_W + 1);
   assign at_mid     = sample_tick && (ph == PH_MID);
   assign start_ok   = (state == RX_START) && at_mid && !vote;
   assign bit_strobe = ((state == RX_DATA) || (state == RX_STOP)) && at_mid;
   assign frame_done = (state == RX_STOP) && at_mid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= RX_IDLE;
         ph     <= '0;
         bitcnt <= '0;
         shreg  <= '0;
      end else if (sample_tick) begin
         case (state)
            RX_IDLE: begin
               if (!rx_line) begin
                  state <= RX_START;
                  ph    <= PW'(1);
               end
            end
            RX_START: begin
               ph <= ph + 1'b1;
               if (ph == PH_MID) begin
                  if (vote) state <= RX_IDLE;
                  else      shreg <= '0;
               end
               if (ph == PH_LAST) begin
                  state  <= RX_DATA;
                  bitcnt <= '0;
               end
            end
            RX_DATA: begin
               ph <= ph + 1'b1;
               if (ph == PH_MID) shreg[bitcnt] <= vote;
               if (ph == PH_LAST) begin
                  if (bitcnt == nbits - 1'b1) state  <= RX_STOP;
                  else                        bitcnt <= bitcnt + 1'b1;
               end
            end
            RX_STOP: begin
               ph <= ph + 1'b1;
               if (ph == PH_MID) state <= RX_IDLE;
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   uart_wr_idle #(.OVS(OVS), .MAXLEN(MAXLEN), .CW(CW)) u_idle (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (sample_tick),
      .in_idle    (state == RX_IDLE),
      .rx         (rx_line),
      .bit_strobe (bit_strobe),
      .bit_val    (vote),
      .count_frame(!idle_after_stop),
      .restart    (start_ok || sleep_req),
      .frame_len  (frame_len),
      .idle_hit   (idle_hit)
   );
   assign idle_flag = idle_hit;

   assign msb       = nine_bit_mode ? shreg[CHAR_W-1] : shreg[CHAR_W-2];
   assign par_bad   = parity_en && ((^shreg) != parity_odd);
   assign wake_mark = asleep && wake_on_mark && msb;
   assign deliver   = frame_done && (!asleep || wake_mark);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_ready   <= 1'b0;
         rx_data    <= '0;
         parity_err <= 1'b0;
         asleep     <= 1'b0;
      end else begin
         rx_ready <= deliver;
         if (deliver) begin
            rx_data    <= shreg;
            parity_err <= par_bad;
         end
         if (sleep_req)
            asleep <= 1'b1;
         else if ((frame_done && wake_mark) || (!wake_on_mark && idle_hit))
            asleep <= 1'b0;
      end
   end

   // R1
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |=> !rx_ready);
   // R6
   sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      asleep && !wake_on_mark |=> !rx_ready);
   // R8
   mark_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready && $past(asleep) && !$past(sleep_req) |-> !asleep);
   // R3
   perr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready && !$past(parity_en) |-> !parity_err);
   // R4
   noise_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_START) && at_mid && vote |=> (state == RX_IDLE));
endmodule

// File: tb/uart_wake_rx_bench.sv
module uart_wake_rx_bench;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_tick = 1'b1;
   logic       rx_line = 1'b1;
   logic       nine_bit_mode = 1'b0;
   logic       parity_en = 1'b0;
   logic       parity_odd = 1'b0;
   logic       wake_on_mark = 1'b0;
   logic       idle_after_stop = 1'b0;
   logic       sleep_req = 1'b0;
   logic [8:0] rx_data;
   logic       rx_ready, parity_err, idle_flag, asleep;

   int n_chk = 0, n_err = 0, rdy_n = 0, idle_n = 0;
   logic [8:0] got_data = '0;
   logic       got_perr = 1'b0;

   always #(CLK_P / 2) clk = ~clk;

   uart_wake_rx u_uart_wake_rx (
      .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rx_line(rx_line),
      .nine_bit_mode(nine_bit_mode), .parity_en(parity_en), .parity_odd(parity_odd),
      .wake_on_mark(wake_on_mark), .idle_after_stop(idle_after_stop),
      .sleep_req(sleep_req), .rx_data(rx_data), .rx_ready(rx_ready),
      .parity_err(parity_err), .idle_flag(idle_flag), .asleep(asleep)
   );

   always @(negedge clk) begin
      if (rx_ready) begin
         rdy_n++;
         got_data = rx_data;
         got_perr = parity_err;
      end
      if (idle_flag) idle_n++;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [8:0] ch, input int nb, input int glitch);
      rx_line = 1'b0;
      wait_n(16);
      for (int i = 0; i < nb; i++) begin
         for (int k = 0; k < 16; k++) begin
            rx_line = (i == glitch && k == 7) ? ~ch[i] : ch[i];
            @(negedge clk);
         end
      end
      rx_line = 1'b1;
      wait_n(16);
   endtask

   task automatic go_sleep();
      sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
   endtask

   task automatic t_reset();
      chk("R13 ready", int'(rx_ready), 0);
      chk("R13 perr", int'(parity_err), 0);
      chk("R13 idle", int'(idle_flag), 0);
      chk("R13 asleep", int'(asleep), 0);
   endtask

   task automatic t_plain();
      int r0;
      r0 = rdy_n;
      send(9'h0A5, 8, -1);
      chk("R1 count", rdy_n - r0, 1);
      chk("R1 data", int'(got_data), 'h0A5);
      nine_bit_mode = 1'b1;
      send(9'h15A, 9, -1);
      chk("R2 data", int'(got_data), 'h15A);
      nine_bit_mode = 1'b0;
      wait_n(250);
   endtask

   task automatic t_parity();
      parity_en = 1'b1;
      send(9'h035, 8, -1);
      chk("R3 even ok", int'(got_perr), 0);
      send(9'h0B5, 8, -1);
      chk("R3 even bad", int'(got_perr), 1);
      chk("R3 data", int'(got_data), 'h0B5);
      nine_bit_mode = 1'b1;
      parity_odd = 1'b1;
      send(9'h1C3, 9, -1);
      chk("R3 odd ok", int'(got_perr), 0);
      send(9'h0C3, 9, -1);
      chk("R3 odd bad", int'(got_perr), 1);
      parity_en = 1'b0;
      parity_odd = 1'b0;
      nine_bit_mode = 1'b0;
      wait_n(250);
   endtask

   task automatic t_noise();
      int r0;
      r0 = rdy_n;
      rx_line = 1'b0;
      wait_n(4);
      rx_line = 1'b1;
      wait_n(40);
      chk("R4 runt start", rdy_n - r0, 0);
      send(9'h03C, 8, -1);
      chk("R4 recover", int'(got_data), 'h03C);
      send(9'h0A5, 8, 0);
      chk("R5 glitch low", int'(got_data), 'h0A5);
      send(9'h0A5, 8, 1);
      chk("R5 glitch high", int'(got_data), 'h0A5);
      wait_n(250);
   endtask

   task automatic t_idle_wake();
      int r0, i0;
      wake_on_mark = 1'b0;
      go_sleep();
      chk("R6 asleep", int'(asleep), 1);
      r0 = rdy_n;
      i0 = idle_n;
      send(9'h055, 8, -1);
      chk("R6 no ready", rdy_n - r0, 0);
      chk("R7 still asleep", int'(asleep), 1);
      wait_n(200);
      chk("R7 woke", int'(asleep), 0);
      chk("R7 idle seen", idle_n - i0, 1);
      send(9'h066, 8, -1);
      chk("R7 delivered", int'(got_data), 'h066);
      wait_n(250);
   endtask

   task automatic t_mark_wake();
      int r0;
      wake_on_mark = 1'b1;
      go_sleep();
      r0 = rdy_n;
      send(9'h012, 8, -1);
      chk("R8 no mark", rdy_n - r0, 0);
      wait_n(250);
      chk("R8 idle ignored", int'(asleep), 1);
      send(9'h093, 8, -1);
      chk("R8 mark count", rdy_n - r0, 1);
      chk("R8 mark data", int'(got_data), 'h093);
      chk("R8 woke", int'(asleep), 0);
      wait_n(250);
      nine_bit_mode = 1'b1;
      go_sleep();
      r0 = rdy_n;
      send(9'h0FF, 9, -1);
      chk("R9 bit7 not mark", rdy_n - r0, 0);
      chk("R9 asleep", int'(asleep), 1);
      send(9'h101, 9, -1);
      chk("R9 bit8 mark", int'(got_data), 'h101);
      chk("R9 woke", int'(asleep), 0);
      nine_bit_mode = 1'b0;
      wake_on_mark = 1'b0;
      wait_n(250);
   endtask

   task automatic t_idle_modes();
      int i0;
      idle_after_stop = 1'b0;
      i0 = idle_n;
      send(9'h0FF, 8, -1);
      wait_n(5);
      chk("R10 not early", idle_n - i0, 0);
      wait_n(10);
      chk("R10 fired once", idle_n - i0, 1);
      wait_n(250);
      idle_after_stop = 1'b1;
      i0 = idle_n;
      send(9'h0FF, 8, -1);
      wait_n(140);
      chk("R11 not early", idle_n - i0, 0);
      wait_n(20);
      chk("R11 fired", idle_n - i0, 1);
      wait_n(250);
      nine_bit_mode = 1'b1;
      i0 = idle_n;
      send(9'h1FF, 9, -1);
      wait_n(160);
      chk("R12 not early", idle_n - i0, 0);
      wait_n(20);
      chk("R12 fired", idle_n - i0, 1);
      wait_n(250);
      chk("R13 single pulse", idle_n - i0, 1);
      nine_bit_mode = 1'b0;
      idle_after_stop = 1'b0;
   endtask

   initial begin
      #(CLK_P * 150000);
      n_err++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      wait_n(3);
      t_reset();
      wait_n(2);
      rst_n = 1'b1;
      wait_n(5);
      t_reset();
      t_plain();
      t_parity();
      t_noise();
      t_idle_wake();
      t_mark_wake();
      t_idle_modes();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule